// File: doc/BRIEF.md
# Masked interrupt status unit

This block collects the interrupt causes of a packet controller into one 8-bit status byte, holds an 8-bit enable mask beside it, and raises a single interrupt line whenever an enabled cause is pending. Software reads status and mask together in one 16-bit word. It clears pending causes by writing ones to an acknowledge byte. It changes the mask with a byte write, or with one 16-bit write that carries the acknowledge and the new mask together, for hosts that cannot issue byte writes.

Some causes are level-derived: receive data available, allocation complete and general error simply mirror their source and go away when the cause does. The rest are edge events: transmit error, transmit empty, receive overrun and link-management change. These are latched until acknowledged. The event generators and any bus bridge sit outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: `rd_data_o[7:0]` is the live status and `rd_data_o[15:8]` is the current mask. The bit map is: 0 receive available (level), 1 transmit error (latched), 2 transmit empty (latched), 3 allocation complete (level), 4 receive overrun (latched), 5 general error (level), 6 reserved early-receive, 7 link-management change (latched). Each cause enters on the same bit of `evt_i`.
- R2: `irq_o` is registered. At each rising edge it takes the OR of (status AND mask) as seen before that edge. It therefore rises and falls one cycle after the masked status changes.
- R3: A latched bit is set by a one on its `evt_i` bit at a clock edge. It stays set until a one is written to the same bit of the acknowledge byte.
- R4: Level bits follow their `evt_i` bits combinationally. Acknowledge writes have no effect on them.
- R5: A byte mask write (`mask_we_i`) loads `mask_i` at the next edge. Without a mask or word write, the mask holds its value.
- R6: A word write (`word_we_i`) uses bits 7:0 as acknowledge and bits 15:8 as the new mask, both at the same edge. If a byte mask write arrives in the same cycle, the word write wins.
- R7: Mask bit 6 always reads zero, whatever value is written. Status bit 6 always reads zero, and `evt_i[6]` is ignored.
- R8: A latched event arriving in the same cycle as its acknowledge stays set.
- R9: A mask of zero keeps `irq_o` low and loses no pending status. Restoring the mask raises `irq_o` again.
- R10: Reset clears every latched bit and the mask, and drives `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Cause inputs: pulses for latched bits, levels for level bits |
| ack_we_i | input | 1 | Acknowledge byte write strobe |
| ack_i | input | 8 | Acknowledge byte, write-one-to-clear |
| mask_we_i | input | 1 | Mask byte write strobe |
| mask_i | input | 8 | Mask byte value |
| word_we_i | input | 1 | Combined word write strobe |
| word_i | input | 16 | Combined word: [7:0] acknowledge, [15:8] mask |
| rd_data_o | output | 16 | Read word: [7:0] status, [15:8] mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Level status bits are due on `rd_data_o` in the same cycle as their input. Latched bits, acknowledges and mask writes appear after one rising edge. `irq_o` follows the masked status one edge later again, so it is due two edges after the stimulus. The bench drives every vector on a falling edge and removes pulses and strobes on the next falling edge, where it samples the read word. It samples `irq_o` one full cycle after that. Directed tests also sample `irq_o` at the intermediate falling edge, to show the single-cycle lag in both directions.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int SRC_W = 8;
  localparam int WORD_W = 2 * SRC_W;
  // bit map of the status byte
  localparam int B_RX_AVAIL = 0;
  localparam int B_TX_ERR = 1;
  localparam int B_TX_EMPTY = 2;
  localparam int B_ALLOC = 3;
  localparam int B_RX_OVRN = 4;
  localparam int B_GEN_ERR = 5;
  localparam int B_EARLY_RX = 6;
  localparam int B_LINK_CHG = 7;
  localparam logic [SRC_W-1:0] STICKY_BITS =
    SRC_W'((1 << B_TX_ERR) | (1 << B_TX_EMPTY) | (1 << B_RX_OVRN) | (1 << B_LINK_CHG));
  localparam logic [SRC_W-1:0] LEVEL_BITS =
    SRC_W'((1 << B_RX_AVAIL) | (1 << B_ALLOC) | (1 << B_GEN_ERR));
  localparam logic [SRC_W-1:0] RSVD_BITS = SRC_W'(1 << B_EARLY_RX);
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W = 8,
  parameter logic [W-1:0] STICKY = '0,
  parameter logic [W-1:0] LEVEL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] status_o
);
  logic unused_bank;
  assign unused_bank = ^(ack_i & ~STICKY) ^ ^(evt_i & ~(STICKY | LEVEL));

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      logic held_q;
      // set wins over clear so a coincident event is kept
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) held_q <= 1'b0;
        else if (evt_i[i]) held_q <= 1'b1;
        else if (ack_i[i]) held_q <= 1'b0;
      end
      assign status_o[i] = held_q;
    end else if (LEVEL[i]) begin : g_level
      assign status_o[i] = evt_i[i];
    end else begin : g_rsvd
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byte_we_i,
  input  logic [W-1:0] byte_d_i,
  input  logic         word_we_i,
  input  logic [W-1:0] word_d_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (word_we_i) mask_d = word_d_i;
    else if (byte_we_i) mask_d = byte_d_i;
    mask_d = mask_d & ~RSVD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_out_reg.sv
module irq_out_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else irq_q <= |(status_i & mask_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic              ack_we_i,
  input  logic [SRC_W-1:0]  ack_i,
  input  logic              mask_we_i,
  input  logic [SRC_W-1:0]  mask_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [SRC_W-1:0] ack_eff, status, mask;

  assign ack_eff = (ack_we_i ? ack_i : '0) | (word_we_i ? word_i[SRC_W-1:0] : '0);

  irq_src_bank #(
    .W(SRC_W), .STICKY(STICKY_BITS), .LEVEL(LEVEL_BITS)
  ) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .ack_i(ack_eff), .status_o(status)
  );

  irq_mask_reg #(
    .W(SRC_W), .RSVD(RSVD_BITS)
  ) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .byte_we_i(mask_we_i), .byte_d_i(mask_i),
    .word_we_i(word_we_i), .word_d_i(word_i[WORD_W-1:SRC_W]),
    .mask_o(mask)
  );

  irq_out_reg #(.W(SRC_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .status_i(status), .mask_i(mask), .irq_o(irq_o)
  );

  assign rd_data_o = {mask, status};
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [7:0]  evt_i,
  input logic        ack_we_i,
  input logic [7:0]  ack_i,
  input logic        mask_we_i,
  input logic [7:0]  mask_i,
  input logic        word_we_i,
  input logic [15:0] word_i,
  input logic [15:0] rd_data_o,
  input logic        irq_o
);
  logic ack1;
  logic unused_chk;
  assign ack1 = (ack_we_i && ack_i[1]) || (word_we_i && word_i[1]);
  assign unused_chk = ^{evt_i, ack_i, mask_i, word_i};

  AST_IRQ_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(rd_data_o[7:0] & rd_data_o[15:8]))); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[14] && !rd_data_o[6]); // R7
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1] && !ack1) |=> rd_data_o[1]); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack1 && !evt_i[1]) |=> !rd_data_o[1]); // R3
  AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[1] |=> rd_data_o[1]); // R8
  AST_LEVEL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[3] == evt_i[3]); // R4
  AST_MASK_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_we_i && !word_we_i) |=> $stable(rd_data_o[15:8])); // R5
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (.*);

// File: tb/irq_status_unit_test.sv
module irq_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt = '0, ack = '0, mask = '0;
  logic        ack_we = 1'b0, mask_we = 1'b0, word_we = 1'b0;
  logic [15:0] word = '0;
  logic [15:0] rd;
  logic        irq;
  int total = 0, bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  irq_status_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .ack_we_i(ack_we), .ack_i(ack),
    .mask_we_i(mask_we), .mask_i(mask), .word_we_i(word_we), .word_i(word),
    .rd_data_o(rd), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0]  lvl;
    logic [7:0]  pulse;
    logic        awe;
    logic [7:0]  a;
    logic        mwe;
    logic [7:0]  m;
    logic        wwe;
    logic [15:0] w;
    logic [15:0] exp_rd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{8'h00, 8'h02, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h0002}, // R3 set
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'hFF, 1'b0, 16'h0000, 16'hBF02}, // R5 R7
    '{8'h00, 8'h00, 1'b1, 8'h02, 1'b0, 8'h00, 1'b0, 16'h0000, 16'hBF00}, // R3 ack
    '{8'h01, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'hBF01}, // R4
    '{8'h01, 8'h00, 1'b1, 8'h01, 1'b0, 8'h00, 1'b0, 16'h0000, 16'hBF01}, // R4 ack ignored
    '{8'h00, 8'h90, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'hBF90}, // R3
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 16'h1410, 16'h1480}, // R6
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h80, 1'b0, 16'h0000, 16'h8080}, // R5
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 16'h0000, 16'h0080}, // R9
    '{8'h00, 8'h04, 1'b1, 8'h04, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h0084}, // R8
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 8'h04, 1'b1, 16'h0800, 16'h0884}, // R6 priority
    '{8'h08, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h088C}, // R4
    '{8'h20, 8'h40, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'h08A4}, // R7 R1
    '{8'h20, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 16'hFF84, 16'hBF20}, // R6 R7
    '{8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 16'h0000, 16'hBF00}  // R4
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic quiet();
    evt = '0; ack_we = 1'b0; ack = '0; mask_we = 1'b0; mask = '0;
    word_we = 1'b0; word = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R10 reset read", rd, 16'h0000);
    chk("R10 reset irq", {15'd0, irq}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      evt = VEC[i].lvl | VEC[i].pulse;
      ack_we = VEC[i].awe; ack = VEC[i].a;
      mask_we = VEC[i].mwe; mask = VEC[i].m;
      word_we = VEC[i].wwe; word = VEC[i].w;
      @(negedge clk);
      quiet();
      evt = VEC[i].lvl;
      chk($sformatf("R1 vec%0d read", i), rd, VEC[i].exp_rd);
      @(negedge clk);
      chk($sformatf("R2 vec%0d irq", i), {15'd0, irq},
          {15'd0, |(VEC[i].exp_rd[7:0] & VEC[i].exp_rd[15:8])});
    end

    // R2 lag on assert and deassert, R9 mask restore
    mask_we = 1'b1; mask = 8'h10;
    @(negedge clk); quiet();
    evt = 8'h10;
    @(negedge clk); evt = '0;
    chk("R2 irq low one cycle after event", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R2 irq high two edges after event", {15'd0, irq}, 16'd1);
    mask_we = 1'b1; mask = 8'h00;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R9 irq low with zero mask", {15'd0, irq}, 16'd0);
    chk("R9 status kept", rd, 16'h0010);
    mask_we = 1'b1; mask = 8'h10;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R9 irq back after unmask", {15'd0, irq}, 16'd1);
    ack_we = 1'b1; ack = 8'h10;
    @(negedge clk); quiet();
    chk("R2 irq still high one cycle after ack", {15'd0, irq}, 16'd1);
    @(negedge clk);
    chk("R2 irq low after ack", {15'd0, irq}, 16'd0);

    // R10 reset in mid run
    evt = 8'h84; mask_we = 1'b1; mask = 8'hFF;
    @(negedge clk); quiet();
    @(negedge clk);
    chk("R10 pre-reset irq", {15'd0, irq}, 16'd1);
    rst_ni = 1'b0;
    #1;
    chk("R10 reset clears read", rd, 16'h0000);
    chk("R10 reset clears irq", {15'd0, irq}, 16'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 state after release", rd, 16'h0000);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule